// File: doc/BRIEF.md
# Byte-to-word ATA bridge for an 8-bit I/O bus

This block sits between an 8-bit PC-style I/O bus and a 16-bit ATA device. The host sees one or two 16-port windows. Offsets 0 and 1 of each window form the 16-bit data register, which the host moves as two byte accesses: low byte first, then high byte. A holding byte on each side joins the pair into one device word.

A device read is triggered by the host read of offset 0. The host gets the low byte at once, and the high byte is kept for the following read of offset 1. A device write is triggered only by the host write of offset 1. The earlier write to offset 0 only fills the holding byte, so the host can use low-then-high word output instructions.

The other offsets reach the command block and the control block as single byte transfers. Every host input is registered on the clock, and every device-side output is registered. As a result, the device strobes follow the host strobes two clock cycles later.

Top module: `xt_ata_bridge`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, all chip selects and both device strobes are high (inactive), `ide_dd_oe` and `host_rdata_oe` are low, and both holding bytes of every channel are cleared. A read of offset 1 before any data read therefore returns 8'h00.
- R2: An access is decoded only when `host_addr[9:4]` equals 6'h30 (window 0, 300h–30Fh) or 6'h31 (window 1, 310h–31Fh, present when `NUM_CH` is 2). Any other address drives no select, no strobe and no host read data enable.
- R3: While `host_aen` is high, no access is decoded, whatever the address.
- R4: A host read of offset 0 asserts `ide_dior_n` low with the channel's select 0 low and `ide_da` = 0. The host receives `ide_dd_in[7:0]`, and `ide_dd_in[15:8]` is stored in that channel's read holding byte.
- R5: A host read of offset 1 returns the channel's read holding byte. It asserts no strobe and no chip select.
- R6: A host write of offset 0 stores the byte in the channel's write holding byte. It asserts no strobe and no chip select.
- R7: A host write of offset 1 asserts `ide_diow_n` low with select 0 low and `ide_da` = 0. It drives `ide_dd_out` = {written byte, write holding byte} with `ide_dd_oe` high.
- R8: Offsets 2–7 assert select 0 with `ide_da` = offset[2:0] and the strobe for the access direction. A write drives {8'h00, byte} on `ide_dd_out`, and a read returns `ide_dd_in[7:0]`.
- R9: Offsets 8–15 assert select 1 with `ide_da` = offset[2:0] and the strobe for the access direction.
- R10: With `swap_ch` = 0, window 0 drives the `pri_*` selects and window 1 drives the `sec_*` selects. With `swap_ch` = 1, the two are exchanged.
- R11: Selects, strobes and host read data change exactly two clock cycles after the host strobe changes, on both assertion and release.
- R12: Each channel keeps its own holding bytes. An access to one window never changes the bytes held for the other.
- R13: At most one chip select is low at any time, and the two device strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 10 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rdata_oe | output | 1 | High while a decoded host read is served |
| host_rd_n | input | 1 | Host I/O read strobe, active low |
| host_wr_n | input | 1 | Host I/O write strobe, active low |
| host_aen | input | 1 | Address enable; high blocks decoding |
| swap_ch | input | 1 | Exchanges which window drives the primary selects |
| ide_dd_in | input | 16 | Device data toward the host |
| ide_dd_out | output | 16 | Device data toward the device |
| ide_dd_oe | output | 1 | Enables the device data drivers |
| ide_da | output | 3 | Device register address |
| ide_dior_n | output | 1 | Device read strobe, active low |
| ide_diow_n | output | 1 | Device write strobe, active low |
| pri_cs0_n | output | 1 | Primary command-block select |
| pri_cs1_n | output | 1 | Primary control-block select |
| sec_cs0_n | output | 1 | Secondary command-block select |
| sec_cs1_n | output | 1 | Secondary control-block select |

## Verification
A holding byte that is stale or mixed up between channels shows up as a wrong byte on the next offset-1 read, or as a wrong upper half of `ide_dd_out` on the next offset-1 write. The bench therefore fills both channels with different values and reads them back across the windows. A decode fault shows up as a wrong select, a wrong strobe or a stray strobe exactly two cycles after the host strobe changes. It shows up even when the access should do nothing: offset-0 writes, offset-1 reads, addresses outside the windows, and accesses with AEN high. Every access is also sampled one cycle after the host strobe edge and again after release, so a wrong latency is caught right away.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Decoded form of the register offset inside one window
  typedef enum logic [1:0] {
    REG_DATA_LO = 2'd0,
    REG_DATA_HI = 2'd1,
    REG_CMD     = 2'd2,
    REG_CTL     = 2'd3
  } reg_kind_t;

  function automatic reg_kind_t kind_of(input logic [3:0] off);
    if (off[3])             return REG_CTL;
    else if (off[2:0] == 0) return REG_DATA_LO;
    else if (off[2:0] == 1) return REG_DATA_HI;
    else                    return REG_CMD;
  endfunction
endpackage

// File: rtl/xtb_win_dec.sv
module xtb_win_dec #(
  parameter int ADDR_W   = 10,
  parameter int WIN_BITS = 4,
  parameter logic [ADDR_W-1:0] WBASE = 10'h300
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] TAG = WBASE[ADDR_W-1:WIN_BITS];

  always_comb begin
    hit = !aen && (addr[ADDR_W-1:WIN_BITS] == TAG);
  end
endmodule

// File: rtl/xtb_hold.sv
module xtb_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_rd,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              cap_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_hold,
  output logic [BYTE_W-1:0] wr_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold <= '0;
      wr_hold <= '0;
    end else begin
      if (cap_rd) rd_hold <= rd_byte;
      if (cap_wr) wr_hold <= wr_byte;
    end
  end

  // R12
  wr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_wr |=> $stable(wr_hold));
  // R12
  rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_rd |=> $stable(rd_hold));
endmodule

// File: rtl/xtb_strobe_gen.sv
module xtb_strobe_gen
  import xtb_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_q,
  input  logic                wr_q,
  input  logic                hit,
  input  logic                pri,
  input  logic [3:0]          off,
  input  logic [BYTE_W-1:0]   wd,
  input  logic [BYTE_W-1:0]   wl,
  input  logic [BYTE_W-1:0]   rl,
  input  logic [BYTE_W-1:0]   dd_lo,
  output logic [BYTE_W-1:0]   host_rdata,
  output logic                host_rdata_oe,
  output logic [2*BYTE_W-1:0] ide_dd_out,
  output logic                ide_dd_oe,
  output logic [2:0]          ide_da,
  output logic                ide_dior_n,
  output logic                ide_diow_n,
  output logic                pri_cs0_n,
  output logic                pri_cs1_n,
  output logic                sec_cs0_n,
  output logic                sec_cs1_n
);
  reg_kind_t kind;
  logic      go_rd, go_wr, go, is_data;

  always_comb begin
    kind    = kind_of(off);
    is_data = (kind == REG_DATA_LO) || (kind == REG_DATA_HI);
    go_rd   = rd_q && hit && (kind != REG_DATA_HI);
    go_wr   = wr_q && hit && (kind != REG_DATA_LO);
    go      = go_rd || go_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_cs0_n     <= 1'b1;
      pri_cs1_n     <= 1'b1;
      sec_cs0_n     <= 1'b1;
      sec_cs1_n     <= 1'b1;
      ide_da        <= '0;
      ide_dior_n    <= 1'b1;
      ide_diow_n    <= 1'b1;
      ide_dd_oe     <= 1'b0;
      ide_dd_out    <= '0;
      host_rdata_oe <= 1'b0;
      host_rdata    <= '0;
    end else begin
      pri_cs0_n     <= !(go && pri && !off[3]);
      pri_cs1_n     <= !(go && pri && off[3]);
      sec_cs0_n     <= !(go && !pri && !off[3]);
      sec_cs1_n     <= !(go && !pri && off[3]);
      ide_da        <= (go && !is_data) ? off[2:0] : 3'd0;
      ide_dior_n    <= !go_rd;
      ide_diow_n    <= !go_wr;
      ide_dd_oe     <= go_wr;
      ide_dd_out    <= (kind == REG_DATA_HI) ? {wd, wl} : {{BYTE_W{1'b0}}, wd};
      host_rdata_oe <= rd_q && hit;
      host_rdata    <= (kind == REG_DATA_HI) ? rl : dd_lo;
    end
  end

  // R13
  one_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~pri_cs0_n, ~pri_cs1_n, ~sec_cs0_n, ~sec_cs1_n}));
  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ide_dior_n && !ide_diow_n));
  // R5
  hi_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_q && hit && off == 4'd1) |=> ide_dior_n);
  // R6
  lo_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_q && hit && off == 4'd0) |=> ide_diow_n);
endmodule

// File: rtl/xt_ata_bridge.sv
module xt_ata_bridge #(
  parameter int ADDR_W   = 10,
  parameter int WIN_BITS = 4,
  parameter int NUM_CH   = 2,
  parameter logic [ADDR_W-1:0] BASE = 10'h300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [9:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_rdata_oe,
  input  logic        host_rd_n,
  input  logic        host_wr_n,
  input  logic        host_aen,
  input  logic        swap_ch,
  input  logic [15:0] ide_dd_in,
  output logic [15:0] ide_dd_out,
  output logic        ide_dd_oe,
  output logic [2:0]  ide_da,
  output logic        ide_dior_n,
  output logic        ide_diow_n,
  output logic        pri_cs0_n,
  output logic        pri_cs1_n,
  output logic        sec_cs0_n,
  output logic        sec_cs1_n
);
  localparam int BYTE_W   = xtb_pkg::BYTE_W;
  localparam int WIN_SIZE = 1 << WIN_BITS;

  logic [ADDR_W-1:0] a_q;
  logic [BYTE_W-1:0] wd_q;
  logic              rd_q, wr_q, aen_q, swap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      wd_q   <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      aen_q  <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      a_q    <= host_addr;
      wd_q   <= host_wdata;
      rd_q   <= !host_rd_n;
      wr_q   <= !host_wr_n;
      aen_q  <= host_aen;
      swap_q <= swap_ch;
    end
  end

  logic [NUM_CH-1:0] hit;
  logic [BYTE_W-1:0] rhold [NUM_CH];
  logic [BYTE_W-1:0] whold [NUM_CH];
  logic [3:0]        off;

  assign off = a_q[3:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] WBASE = BASE + ADDR_W'(ch * WIN_SIZE);
    logic lo_sel;

    xtb_win_dec #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WBASE(WBASE)) i_dec (
      .addr (a_q),
      .aen  (aen_q),
      .hit  (hit[ch])
    );

    assign lo_sel = hit[ch] && (off == 4'd0);

    xtb_hold #(.BYTE_W(BYTE_W)) i_hold (
      .clk     (clk),
      .rst     (rst),
      .cap_rd  (rd_q && lo_sel),
      .rd_byte (ide_dd_in[2*BYTE_W-1:BYTE_W]),
      .cap_wr  (wr_q && lo_sel),
      .wr_byte (wd_q),
      .rd_hold (rhold[ch]),
      .wr_hold (whold[ch])
    );
  end

  logic win_idx, any_hit, pri;

  always_comb begin
    win_idx = hit[NUM_CH-1] && (NUM_CH > 1);
    any_hit = |hit;
    pri     = (NUM_CH == 1) || (win_idx == swap_q);
  end

  xtb_strobe_gen #(.BYTE_W(BYTE_W)) i_stb (
    .clk           (clk),
    .rst           (rst),
    .rd_q          (rd_q),
    .wr_q          (wr_q),
    .hit           (any_hit),
    .pri           (pri),
    .off           (off),
    .wd            (wd_q),
    .wl            (whold[win_idx]),
    .rl            (rhold[win_idx]),
    .dd_lo         (ide_dd_in[BYTE_W-1:0]),
    .host_rdata    (host_rdata),
    .host_rdata_oe (host_rdata_oe),
    .ide_dd_out    (ide_dd_out),
    .ide_dd_oe     (ide_dd_oe),
    .ide_da        (ide_da),
    .ide_dior_n    (ide_dior_n),
    .ide_diow_n    (ide_diow_n),
    .pri_cs0_n     (pri_cs0_n),
    .pri_cs1_n     (pri_cs1_n),
    .sec_cs0_n     (sec_cs0_n),
    .sec_cs1_n     (sec_cs1_n)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ide_dior_n && ide_diow_n && pri_cs0_n && pri_cs1_n &&
             sec_cs0_n && sec_cs1_n && !ide_dd_oe && !host_rdata_oe));
  // R3
  aen_block_chk: assert property (@(posedge clk) disable iff (rst)
    aen_q |=> (ide_dior_n && ide_diow_n && pri_cs0_n && pri_cs1_n &&
               sec_cs0_n && sec_cs1_n && !host_rdata_oe));
  // R7
  write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !ide_diow_n |-> ide_dd_oe);
endmodule

// File: tb/test_xt_ata_bridge.sv
module test_xt_ata_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rdata_oe;
  logic        host_rd_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic        host_aen = 1'b0;
  logic        swap_ch = 1'b0;
  logic [15:0] ide_dd_in = '0;
  logic [15:0] ide_dd_out;
  logic        ide_dd_oe;
  logic [2:0]  ide_da;
  logic        ide_dior_n, ide_diow_n;
  logic        pri_cs0_n, pri_cs1_n, sec_cs0_n, sec_cs1_n;

  always #2 clk = ~clk;

  xt_ata_bridge i_xt_ata_bridge (.*);

  typedef struct {
    logic [34:0] val;
    logic [34:0] msk;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  event smp_ev;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  function automatic logic [34:0] observe();
    return {pri_cs0_n, pri_cs1_n, sec_cs0_n, sec_cs1_n, ide_da, ide_dior_n,
            ide_diow_n, ide_dd_oe, ide_dd_out, host_rdata_oe, host_rdata};
  endfunction

  // Monitor: pops expected items as the driver reaches each sample point
  initial begin
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [34:0] o;
        e = exp_q.pop_front();
        o = observe();
        n_chk++;
        if ((o & e.msk) !== (e.val & e.msk)) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h (mask %h)", e.req, o, e.val, e.msk);
        end
      end
    end
  end

  task automatic push(input logic [34:0] v, input logic [34:0] m, input string r);
    exp_t e;
    e.val = v; e.msk = m; e.req = r;
    exp_q.push_back(e);
    -> smp_ev;
  endtask

  // Idle: no select, no strobe, no drive, no host read data
  task automatic push_idle(input string r);
    push({4'b1111, 3'd0, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0},
         {4'hF, 3'd0, 3'b111, 16'h0, 1'b1, 8'h0}, r);
  endtask

  task automatic xfer(input logic [9:0] a, input bit wr, input logic [7:0] wd,
                      input bit aen, input int csel, input logic [2:0] da,
                      input bit strb, input bit dec, input logic [15:0] dd,
                      input logic [7:0] rdat, input string r);
    logic [3:0]  cs;
    logic [34:0] v, m;
    @(negedge clk);
    host_addr = a; host_wdata = wd; host_aen = aen;
    if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
    @(negedge clk);
    push_idle({r, " R11 lead"});
    @(negedge clk);
    cs = 4'b1111;
    if (csel > 0) cs[4-csel] = 1'b0;
    v = {cs, da, !(strb && !wr), !(strb && wr), strb && wr, dd, dec && !wr, rdat};
    m = {4'hF, strb ? 3'b111 : 3'b000, 3'b111, (strb && wr) ? 16'hFFFF : 16'h0,
         1'b1, (dec && !wr) ? 8'hFF : 8'h0};
    push(v, m, r);
    @(negedge clk);
    host_rd_n = 1'b1; host_wr_n = 1'b1; host_aen = 1'b0;
    @(negedge clk);
    @(negedge clk);
    push_idle({r, " R11 trail"});
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push_idle("R1 reset outputs");
    rst = 1'b0;
    // R1: holding byte cleared by reset
    xfer(10'h301, 0, 8'h00, 0, 0, 3'd0, 0, 1, 16'h0, 8'h00, "R1 cleared hold");
    // R4: data read low byte, high byte held
    ide_dd_in = 16'hA55A;
    xfer(10'h300, 0, 8'h00, 0, 1, 3'd0, 1, 1, 16'h0, 8'h5A, "R4 data read");
    ide_dd_in = 16'h0000;
    // R5: high byte from holding register, no strobe
    xfer(10'h301, 0, 8'h00, 0, 0, 3'd0, 0, 1, 16'h0, 8'hA5, "R5 held high");
    // R6 then R7: low byte held, word written on high byte
    xfer(10'h300, 1, 8'h34, 0, 0, 3'd0, 0, 1, 16'h0, 8'h00, "R6 low held");
    xfer(10'h301, 1, 8'h12, 0, 1, 3'd0, 1, 1, 16'h1234, 8'h00, "R7 word write");
    // R8: command block
    xfer(10'h305, 1, 8'h7E, 0, 1, 3'd5, 1, 1, 16'h007E, 8'h00, "R8 cmd write");
    ide_dd_in = 16'hFFC3;
    xfer(10'h307, 0, 8'h00, 0, 1, 3'd7, 1, 1, 16'h0, 8'hC3, "R8 cmd read");
    // R9: control block
    xfer(10'h30E, 0, 8'h00, 0, 2, 3'd6, 1, 1, 16'h0, 8'hC3, "R9 ctl read");
    xfer(10'h309, 1, 8'h04, 0, 2, 3'd1, 1, 1, 16'h0004, 8'h00, "R9 ctl write");
    // R2: second window and out-of-window
    xfer(10'h312, 0, 8'h00, 0, 3, 3'd2, 1, 1, 16'h0, 8'hC3, "R2 second window");
    xfer(10'h320, 1, 8'h55, 0, 0, 3'd0, 0, 0, 16'h0, 8'h00, "R2 outside");
    xfer(10'h2FF, 0, 8'h00, 0, 0, 3'd0, 0, 0, 16'h0, 8'h00, "R2 below");
    // R3: AEN blocks decode
    xfer(10'h302, 0, 8'h00, 1, 0, 3'd0, 0, 0, 16'h0, 8'h00, "R3 aen read");
    xfer(10'h301, 1, 8'h66, 1, 0, 3'd0, 0, 0, 16'h0, 8'h00, "R3 aen write");
    // R12: separate holding bytes per channel
    xfer(10'h300, 1, 8'h11, 0, 0, 3'd0, 0, 1, 16'h0, 8'h00, "R12 ch0 low");
    xfer(10'h310, 1, 8'h22, 0, 0, 3'd0, 0, 1, 16'h0, 8'h00, "R12 ch1 low");
    xfer(10'h301, 1, 8'h99, 0, 1, 3'd0, 1, 1, 16'h9911, 8'h00, "R12 ch0 word");
    xfer(10'h311, 1, 8'h88, 0, 3, 3'd0, 1, 1, 16'h8822, 8'h00, "R12 ch1 word");
    ide_dd_in = 16'h3C00;
    xfer(10'h310, 0, 8'h00, 0, 3, 3'd0, 1, 1, 16'h0, 8'h00, "R12 ch1 read");
    ide_dd_in = 16'h0000;
    xfer(10'h301, 0, 8'h00, 0, 0, 3'd0, 0, 1, 16'h0, 8'hA5, "R12 ch0 kept");
    xfer(10'h311, 0, 8'h00, 0, 0, 3'd0, 0, 1, 16'h0, 8'h3C, "R12 ch1 kept");
    // R10: swapped windows
    swap_ch = 1'b1;
    xfer(10'h312, 0, 8'h00, 0, 1, 3'd2, 1, 1, 16'h0, 8'h00, "R10 upper as primary");
    xfer(10'h30A, 1, 8'h01, 0, 4, 3'd2, 1, 1, 16'h0001, 8'h00, "R10 lower as secondary");
    swap_ch = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule